// File: doc/BRIEF.md
# Double-precision round-and-pack unit

This unit takes the unrounded result of a double-precision operation and turns it into a finished 64-bit word. The result arrives as a sign, a signed exponent and a 64-bit significand. It produces the packed word and three exception flags. The significand is normalised with its leading one at bit 62. Ten guard bits sit below the result's least significant bit, so that bit has weight 0x400. The exponent input is one less than the biased exponent of the result. The leading one is not stripped before packing: it is added into the exponent field when the significand is packed. A carry out of rounding therefore moves into the exponent field without any separate correction.

The rounding mode is chosen per operation by a 3-bit code. There are five IEEE-style modes and a sixth, non-IEEE round-to-odd mode. Round-to-odd leaves exact values alone and sends any inexact value to whichever neighbour has an odd fraction. On overflow it saturates to the largest finite magnitude. Results with a negative exponent are shifted right into the subnormal range before rounding. The shifted-out bits are gathered into a sticky bit, and the round-to-odd increment is chosen again from the shifted value. The output is registered, with one cycle of latency. A parameter can make tiny results flush to a signed zero. This parameter is off by default.

Top module: `rnd_pack_unit`

## Requirements
- R1: Code 0 rounds to nearest, and an exact half-way case (discarded bits = 0x200) ends with fraction LSB 0. Codes 6 and 7 behave exactly like code 0.
- R2: Code 1 rounds toward minus infinity: the magnitude goes up by one ulp only when the sign is 1 and a discarded bit is nonzero. Code 2 rounds toward plus infinity: the same happens only when the sign is 0.
- R3: Code 3 truncates: the fraction equals significand bits 61..10 whatever the discarded bits hold.
- R4: Code 4 rounds to nearest with half-way cases rounded away from zero.
- R5: Code 5 (round-to-odd) leaves a value that needs no rounding unchanged. Any inexact value ends with fraction bit 0 equal to 1.
- R6: out_inexact is 1 exactly when any of the ten discarded bits (after the subnormal shift) is nonzero, or when overflow occurs.
- R7: Overflow occurs when the exponent input is above 0x7FD, or equals 0x7FD and the rounding increment carries into significand bit 63. Overflow sets out_overflow and out_inexact.
- R8: On overflow the word is infinity (exponent field 0x7FF, fraction 0) if the mode is not 5 and the increment is nonzero. Otherwise it is the largest finite magnitude (exponent field 0x7FE, fraction all ones). The sign is kept in both cases.
- R9: A negative exponent input E shifts the significand right by -E, with every lost bit ORed into bit 0, and gives exponent field 0. A shift of 64 or more leaves only that sticky bit. The code-5 increment is chosen from the shifted significand.
- R10: out_underflow is 1 exactly when the exponent input is negative, there is no overflow, and the result is inexact.
- R11: A rounding carry out of the fraction adds one to the exponent field. This includes a subnormal rounding up to exponent field 1 with fraction 0.
- R12: The outputs appear one clock after the inputs. While rst_n is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | 13 | Signed exponent, one below the biased exponent |
| in_sig | input | 64 | Significand, leading one at bit 62, 10 guard bits |
| in_mode | input | 3 | Rounding mode code (0..5, 6 and 7 as 0) |
| out_word | output | 64 | Packed {sign, 11-bit exponent, 52-bit fraction} |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The unit holds no state apart from its output register, so a fault in the datapath shows up in the word or flags of the same operation, one clock after it is applied. A wrong increment choice shows up as a fraction that is off by one ulp or has the wrong parity. A lost sticky bit shows up as a missing inexact or underflow flag, or a wrong LSB on a subnormal. A wrong overflow decision shows up as infinity where the largest finite value belongs, or the other way round. The directed cases therefore sit on the decision edges: exact half-way points, exponent 0x7FD with and without a carry, a round-to-odd subnormal whose parity changes under the shift, and a subnormal that rounds into the normal range.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_DOWN      = 3'd1,
    RM_UP        = 3'd2,
    RM_ZERO      = 3'd3,
    RM_TIES_AWAY = 3'd4,
    RM_ODD       = 3'd5
  } rnd_mode_e;

  typedef struct packed {
    logic overflow;
    logic underflow;
    logic inexact;
  } rnd_flags_t;

  // Codes outside the defined set fall back to nearest-even.
  function automatic logic is_near_even(input logic [2:0] m);
    return (m == 3'(RM_NEAR_EVEN)) || (m > 3'(RM_ODD));
  endfunction

endpackage

// File: rtl/rnd_incr_sel.sv
module rnd_incr_sel
  import rnd_pkg::*;
#(
  parameter int GUARD_W = 10
) (
  input  logic [2:0]         mode,
  input  logic               sign,
  input  logic [GUARD_W:0]   lsb_win,   // result LSB plus guard bits
  output logic [GUARD_W-1:0] inc
);

  localparam logic [GUARD_W-1:0] HALF = {1'b1, {(GUARD_W-1){1'b0}}};
  localparam logic [GUARD_W-1:0] FULL = {GUARD_W{1'b1}};

  always_comb begin
    inc = HALF;
    if (!is_near_even(mode)) begin
      case (mode)
        3'(RM_DOWN):      inc = sign ? FULL : '0;
        3'(RM_UP):        inc = sign ? '0 : FULL;
        3'(RM_ZERO):      inc = '0;
        3'(RM_TIES_AWAY): inc = HALF;
        3'(RM_ODD):       inc = lsb_win[GUARD_W] ? '0 : FULL;
        default:          inc = HALF;
      endcase
    end
  end

endmodule

// File: rtl/rnd_jam_shift.sv
module rnd_jam_shift #(
  parameter int W     = 64,
  parameter int AMT_W = 13
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);

  logic [W-1:0] lost_mask;
  logic         sticky;

  always_comb begin
    lost_mask = '0;
    sticky    = 1'b0;
    dout      = din;
    if (amt >= AMT_W'(W)) begin
      sticky = |din;
      dout   = {{(W-1){1'b0}}, sticky};
    end else begin
      lost_mask = ~({W{1'b1}} << amt);
      sticky    = |(din & lost_mask);
      dout      = (din >> amt) | {{(W-1){1'b0}}, sticky};
    end
  end

endmodule

// File: rtl/rnd_pack_unit.sv
module rnd_pack_unit
  import rnd_pkg::*;
#(
  parameter int SIG_W     = 64,
  parameter int GUARD_W   = 10,
  parameter int EXP_IN_W  = 13,
  parameter int EXP_FLD_W = 11,
  parameter bit FLUSH_TZ  = 1'b0,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_sign,
  input  logic [EXP_IN_W-1:0] in_exp,
  input  logic [SIG_W-1:0]    in_sig,
  input  logic [2:0]          in_mode,
  output logic [SIG_W-1:0]    out_word,
  output logic                out_overflow,
  output logic                out_underflow,
  output logic                out_inexact
);

  localparam int FRAC_W = SIG_W - GUARD_W - 2;
  localparam int MANT_W = SIG_W - GUARD_W;
  localparam int WORD_W = 1 + EXP_FLD_W + FRAC_W;
  localparam logic signed [EXP_IN_W-1:0] EXP_LIM = EXP_IN_W'((1 << EXP_FLD_W) - 3);
  localparam logic [GUARD_W-1:0] HALF = {1'b1, {(GUARD_W-1){1'b0}}};

  // ---------------- classification ----------------
  logic signed [EXP_IN_W-1:0] exp_s;
  logic                       tiny_c;
  logic [EXP_IN_W-1:0]        shamt;

  assign exp_s  = $signed(in_exp);
  assign tiny_c = exp_s < 0;
  assign shamt  = EXP_IN_W'(-in_exp);

  // ---------------- overflow decision on the unshifted value ----------------
  logic [GUARD_W-1:0] inc_pre;
  logic               pre_top;
  logic               ovf_c;
  logic               ovf_inf;

  rnd_incr_sel #(.GUARD_W(GUARD_W)) i_inc_pre (
    .mode    (in_mode),
    .sign    (in_sign),
    .lsb_win (in_sig[GUARD_W:0]),
    .inc     (inc_pre)
  );

  assign pre_top = |((in_sig + SIG_W'(inc_pre)) >> (SIG_W - 1));
  assign ovf_c   = (exp_s > EXP_LIM) || ((exp_s == EXP_LIM) && pre_top);
  assign ovf_inf = (in_mode != 3'(RM_ODD)) && (inc_pre != '0);

  // ---------------- denormalising shift ----------------
  logic [SIG_W-1:0] sig_shift;
  logic [SIG_W-1:0] sig_d;
  logic [EXP_FLD_W-1:0] exp_d;

  rnd_jam_shift #(.W(SIG_W), .AMT_W(EXP_IN_W)) i_jam (
    .din  (in_sig),
    .amt  (shamt),
    .dout (sig_shift)
  );

  assign sig_d = tiny_c ? sig_shift : in_sig;
  assign exp_d = tiny_c ? '0 : in_exp[EXP_FLD_W-1:0];

  // ---------------- rounding on the (possibly shifted) value ----------------
  logic [GUARD_W-1:0] inc_post;
  logic [SIG_W-1:0]   rnd_sum;
  logic [MANT_W-1:0]  mant;
  logic [MANT_W-1:0]  mant_f;
  logic               tie_c;
  logic               inexact_bits;
  logic [WORD_W-2:0]  packed_mag;

  rnd_incr_sel #(.GUARD_W(GUARD_W)) i_inc_post (
    .mode    (in_mode),
    .sign    (in_sign),
    .lsb_win (sig_d[GUARD_W:0]),
    .inc     (inc_post)
  );

  assign rnd_sum      = sig_d + SIG_W'(inc_post);
  assign mant         = MANT_W'(rnd_sum >> GUARD_W);
  assign tie_c        = is_near_even(in_mode) && (sig_d[GUARD_W-1:0] == HALF);
  assign mant_f       = mant & ~{{(MANT_W-1){1'b0}}, tie_c};
  assign inexact_bits = |sig_d[GUARD_W-1:0];
  assign packed_mag   = {exp_d, {FRAC_W{1'b0}}} + (WORD_W-1)'(mant_f);

  // ---------------- optional flush of tiny results ----------------
  logic ftz_hit;
  generate
    if (FLUSH_TZ) begin : g_ftz
      assign ftz_hit = tiny_c;
    end else begin : g_no_ftz
      assign ftz_hit = 1'b0;
    end
  endgenerate

  // ---------------- next-state word and flags ----------------
  logic [WORD_W-1:0] word_c;
  rnd_flags_t        flags_c;

  always_comb begin
    if (ovf_c) begin
      word_c = ovf_inf ? {in_sign, {EXP_FLD_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {in_sign, {(EXP_FLD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (ftz_hit) begin
      word_c = {in_sign, {(WORD_W-1){1'b0}}};
    end else begin
      word_c = {in_sign, packed_mag};
    end
    flags_c.overflow  = ovf_c;
    flags_c.inexact   = ovf_c | ftz_hit | inexact_bits;
    flags_c.underflow = !ovf_c && tiny_c && (inexact_bits || ftz_hit);
  end

  // ---------------- output stage ----------------
  generate
    if (REG_OUT) begin : g_reg
      logic [WORD_W-1:0] word_q;
      rnd_flags_t        flags_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q  <= '0;
          flags_q <= '0;
        end else begin
          word_q  <= word_c;
          flags_q <= flags_c;
        end
      end

      assign out_word      = word_q;
      assign out_overflow  = flags_q.overflow;
      assign out_underflow = flags_q.underflow;
      assign out_inexact   = flags_q.inexact;

      // R3: truncation keeps the incoming fraction bits for a normal result
      p_trunc_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode == 3'(RM_ZERO) && !ovf_c && !tiny_c && in_sig[SIG_W-2])
        |=> out_word[FRAC_W-1:0] == $past(in_sig[SIG_W-3:GUARD_W]));

      // R5: an inexact round-to-odd result always has an odd fraction
      p_odd_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode == 3'(RM_ODD) && !ovf_c && inexact_bits && !ftz_hit)
        |=> out_word[0]);

      // R6: a normal value with clear guard bits is exact
      p_exact_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tiny_c && !ovf_c && in_sig[GUARD_W-1:0] == '0)
        |=> !out_inexact);

      // R8: any overflow result has the top exponent bits all set
      p_ovf_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (out_word[WORD_W-2 -: (EXP_FLD_W-1)] == {(EXP_FLD_W-1){1'b1}}));

      // R10: underflow only follows a negative exponent input
      p_uf_needs_tiny_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exp[EXP_IN_W-1] |=> !out_underflow);
    end else begin : g_comb
      assign out_word      = word_c;
      assign out_overflow  = flags_c.overflow;
      assign out_underflow = flags_c.underflow;
      assign out_inexact   = flags_c.inexact;
    end
  endgenerate

endmodule

// File: tb/test_rnd_pack_unit.sv
`timescale 1ns/1ps
module test_rnd_pack_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_sign;
  logic [12:0] in_exp;
  logic [63:0] in_sig;
  logic [2:0]  in_mode;
  logic [63:0] out_word;
  logic        out_overflow, out_underflow, out_inexact;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  rnd_pack_unit i_rnd_pack_unit (
    .clk, .rst_n, .in_sign, .in_exp, .in_sig, .in_mode,
    .out_word, .out_overflow, .out_underflow, .out_inexact
  );

  localparam logic [51:0] FE   = 52'h1_2345_6789_ABCE;
  localparam logic [51:0] FO   = 52'h1_2345_6789_ABCF;
  localparam logic [51:0] ONES = {52{1'b1}};
  localparam logic [12:0] E1   = 13'h03FE;

  function automatic logic [63:0] nsig(input logic [51:0] f, input logic [9:0] g);
    return {2'b01, f, g};
  endfunction

  function automatic logic [63:0] w1(input logic s, input logic [51:0] f);
    return {s, 11'h3FF, f};
  endfunction

  task automatic check(input string req, input logic [63:0] ew,
                       input logic eo, input logic eu, input logic ei);
    n_checks++;
    if (out_word !== ew || out_overflow !== eo || out_underflow !== eu || out_inexact !== ei) begin
      n_fail++;
      $display("FAIL %s: got word=%h o/u/i=%b%b%b expected word=%h o/u/i=%b%b%b",
               req, out_word, out_overflow, out_underflow, out_inexact, ew, eo, eu, ei);
    end
  endtask

  task automatic run(input string req, input logic s, input logic [12:0] e,
                     input logic [63:0] sig, input logic [2:0] m,
                     input logic [63:0] ew, input logic eo, input logic eu, input logic ei);
    @(negedge clk);
    in_sign = s; in_exp = e; in_sig = sig; in_mode = m;
    @(negedge clk);
    check(req, ew, eo, eu, ei);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_sign = 1'b1; in_exp = 13'h7FF; in_sig = '1; in_mode = 3'd2;
    repeat (3) @(negedge clk);
    check("R12 reset", 64'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_nearest;
    run("R1 below half",  0, E1, nsig(FE, 10'h1FF), 3'd0, w1(0, FE),     0, 0, 1);
    run("R1 above half",  0, E1, nsig(FE, 10'h201), 3'd0, w1(0, FE + 1), 0, 0, 1);
    run("R1 tie even",    0, E1, nsig(FE, 10'h200), 3'd0, w1(0, FE),     0, 0, 1);
    run("R1 tie odd",     1, E1, nsig(FO, 10'h200), 3'd0, w1(1, FO + 1), 0, 0, 1);
    run("R1 code6 tie",   0, E1, nsig(FO, 10'h200), 3'd6, w1(0, FO + 1), 0, 0, 1);
    run("R1 code7 tie",   0, E1, nsig(FE, 10'h200), 3'd7, w1(0, FE),     0, 0, 1);
  endtask

  task automatic t_directed;
    run("R2 up pos",   0, E1, nsig(FE, 10'h001), 3'd2, w1(0, FE + 1), 0, 0, 1);
    run("R2 up neg",   1, E1, nsig(FE, 10'h001), 3'd2, w1(1, FE),     0, 0, 1);
    run("R2 down neg", 1, E1, nsig(FE, 10'h001), 3'd1, w1(1, FE + 1), 0, 0, 1);
    run("R2 down pos", 0, E1, nsig(FE, 10'h3FF), 3'd1, w1(0, FE),     0, 0, 1);
  endtask

  task automatic t_toward_zero;
    run("R3 truncate", 1, E1, nsig(FO, 10'h3FF), 3'd3, w1(1, FO), 0, 0, 1);
  endtask

  task automatic t_ties_away;
    run("R4 tie away",  0, E1, nsig(FE, 10'h200), 3'd4, w1(0, FE + 1), 0, 0, 1);
    run("R4 below half", 1, E1, nsig(FE, 10'h1FF), 3'd4, w1(1, FE),    0, 0, 1);
  endtask

  task automatic t_odd;
    run("R5 even to odd", 0, E1, nsig(FE, 10'h001), 3'd5, w1(0, FO), 0, 0, 1);
    run("R5 odd stays",   1, E1, nsig(FO, 10'h3FF), 3'd5, w1(1, FO), 0, 0, 1);
    run("R5 exact even",  0, E1, nsig(FE, 10'h000), 3'd5, w1(0, FE), 0, 0, 0);
  endtask

  task automatic t_exact;
    run("R6 exact nearest", 0, E1, nsig(FO, 10'h000), 3'd0, w1(0, FO), 0, 0, 0);
    run("R6 exact up",      1, E1, nsig(FE, 10'h000), 3'd2, w1(1, FE), 0, 0, 0);
  endtask

  task automatic t_mant_carry;
    run("R11 fraction carry", 0, E1, nsig(ONES, 10'h001), 3'd2,
        {1'b0, 11'h400, 52'h0}, 0, 0, 1);
    run("R11 subnormal to normal", 0, 13'h1FFF, 64'h7FFF_FFFF_FFFF_FFFF, 3'd0,
        64'h0010_0000_0000_0000, 0, 1, 1);
  endtask

  task automatic t_overflow;
    run("R8 big nearest inf",  0, 13'h07FE, nsig(FE, 10'h000), 3'd0, 64'h7FF0_0000_0000_0000, 1, 0, 1);
    run("R8 big odd max",      1, 13'h07FE, nsig(FE, 10'h000), 3'd5, 64'hFFEF_FFFF_FFFF_FFFF, 1, 0, 1);
    run("R8 big zero max",     0, 13'h07FE, nsig(FE, 10'h000), 3'd3, 64'h7FEF_FFFF_FFFF_FFFF, 1, 0, 1);
    run("R8 big down pos max", 0, 13'h07FE, nsig(FE, 10'h000), 3'd1, 64'h7FEF_FFFF_FFFF_FFFF, 1, 0, 1);
    run("R7 edge carry inf",   0, 13'h07FD, nsig(ONES, 10'h3FF), 3'd0, 64'h7FF0_0000_0000_0000, 1, 0, 1);
    run("R7 edge no carry",    0, 13'h07FD, nsig(ONES, 10'h3FF), 3'd3, 64'h7FEF_FFFF_FFFF_FFFF, 0, 0, 1);
    run("R7 edge odd no ovf",  0, 13'h07FD, nsig(ONES, 10'h001), 3'd5, 64'h7FEF_FFFF_FFFF_FFFF, 0, 0, 1);
    run("R7 edge down neg",    1, 13'h07FD, nsig(ONES, 10'h001), 3'd1, 64'hFFF0_0000_0000_0000, 1, 0, 1);
  endtask

  task automatic t_subnormal;
    run("R10 tiny exact",      0, 13'h1FFF, 64'h4000_0000_0000_0000, 3'd0, 64'h0008_0000_0000_0000, 0, 0, 0);
    run("R9 shift truncate",   0, 13'h1FFF, 64'h4000_0000_0000_0400, 3'd3, 64'h0008_0000_0000_0000, 0, 1, 1);
    run("R9 odd recomputed",   0, 13'h1FFF, 64'h4000_0000_0000_0400, 3'd5, 64'h0008_0000_0000_0001, 0, 1, 1);
    run("R9 shifted tie even", 0, 13'h1FFF, 64'h4000_0000_0000_0400, 3'd0, 64'h0008_0000_0000_0000, 0, 1, 1);
    run("R9 far shift up",     0, 13'h1F9C, 64'h4000_0000_0000_0000, 3'd2, 64'h0000_0000_0000_0001, 0, 1, 1);
    run("R9 far shift zero",   0, 13'h1F9C, 64'h4000_0000_0000_0000, 3'd3, 64'h0000_0000_0000_0000, 0, 1, 1);
    run("R9 far shift down",   1, 13'h1F9C, 64'h4000_0000_0000_0000, 3'd1, 64'h8000_0000_0000_0001, 0, 1, 1);
    run("R10 exp zero normal", 0, 13'h0000, 64'h4000_0000_0000_0000, 3'd0, 64'h0010_0000_0000_0000, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_nearest();
    t_directed();
    t_toward_zero();
    t_ties_away();
    t_odd();
    t_exact();
    t_mant_carry();
    t_overflow();
    t_subnormal();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no finish expected finish within 20000 cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule